// File: doc/BRIEF.md
# Deglitched Adaptive-Step Tracking Converter

This block is the digital half of a tracking converter that follows a sensed rectified voltage. It drives a reference code to an external DAC and reads back a single-bit comparator result. The result is 1 when the sensed voltage is above the reference. The raw comparator bit first goes through a deglitcher with a programmable minimum pulse width, so that short ringing pulses never reach the tracking logic.

A controller with three states handles the sequence. In `ST_IDLE` the reference is held. A rising edge on `pwm_en` moves it to `ST_WAIT`, where a start timer counts up to a programmable threshold. When the timer reaches the threshold the controller moves to `ST_TRACK` and resets the step adapter. In `ST_TRACK` the reference moves one step per cycle, toward the qualified comparator decision. A low `pwm_en` returns the controller to `ST_IDLE` from either `ST_WAIT` or `ST_TRACK`. Each falling edge of `pwm_en` latches the reference to the capture output and raises a one-cycle strobe.

The step is either a fixed register value or chosen automatically. In automatic mode it grows while decisions keep the same direction, so the reference can catch up with a moving input. It shrinks on every reversal, so it settles around a steady input. A non-zero deglitch width delays the qualified bit by that many cycles, so software should raise the start threshold by the same amount.

Top module: `vrect_tracker`

## Requirements
- R1: During and after reset, with `pwm_en` low, `ref_out` is 0, `cap_valid` is 0 and `cap_value` is 0.
- R2: With `cfg_dgl_width` = 0, the qualified comparator bit equals `cmp_raw` in the same cycle, with no added delay.
- R3: With `cfg_dgl_width` = W > 0, a `cmp_raw` level that lasts fewer than W clock edges has no effect on `ref_out`. A level that persists reaches the qualified bit exactly W cycles later than it would with W = 0.
- R4: Number as edge 1 the first rising clock edge at which `pwm_en` is sampled high. With `cfg_start_thr` = T, the first reference update happens at edge T+3.
- R5: In each tracking cycle, a qualified bit of 1 adds the current step to `ref_out` and a qualified bit of 0 subtracts it.
- R6: With `cfg_auto_step` = 1, the step is 1 at the start of every tracking window. It doubles after every second consecutive same-direction decision. On each direction reversal it halves, never going below 1, and the reversing decision itself uses the step held before halving.
- R7: The automatic step never exceeds `cfg_step_max`. A `cfg_step_max` of 0 is treated as 1.
- R8: With `cfg_auto_step` = 0, every tracking decision uses `cfg_fixed_step` as the step.
- R9: `ref_out` saturates at 0 and at its full-scale code (all ones) and never wraps.
- R10: On a falling edge of `pwm_en`, `cap_value` takes the value `ref_out` held at that edge and `cap_valid` is high for exactly one cycle. `ref_out` does not change while `pwm_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_en | input | 1 | PWM enable; its rising edge arms tracking, its falling edge captures |
| cmp_raw | input | 1 | Raw comparator bit (1 = sensed voltage above reference) |
| cfg_dgl_width | input | DGL_W (4) | Deglitch minimum pulse width in cycles, 0 = bypass |
| cfg_start_thr | input | TMR_W (8) | Start timer threshold |
| cfg_auto_step | input | 1 | 1 = automatic step, 0 = fixed step |
| cfg_fixed_step | input | REF_W (8) | Step used in fixed mode |
| cfg_step_max | input | REF_W (8) | Upper clamp on the automatic step |
| ref_out | output | REF_W (8) | Reference code to the DAC |
| cap_value | output | REF_W (8) | Reference captured at the falling edge of `pwm_en` |
| cap_valid | output | 1 | One-cycle strobe marking a new `cap_value` |

## Verification
Capture and a tracking step compete for the same edge: the edge at which `pwm_en` is first seen low is also an edge at which the controller is still in `ST_TRACK` with a decision pending. The bench provokes this by dropping `pwm_en` while the comparator keeps asking for upward steps. It judges the result by requiring that `cap_value` equals the last reference before the drop and that `ref_out` stays at that value afterwards. A second overlap, a deglitch qualification completing in the same window as a tracking start, is judged by counting the exact edge of the first reference move.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_TRACK = 2'd2
    } trk_state_e;
endpackage

// File: rtl/vrt_deglitch.sv
module vrt_deglitch #(
    parameter int DGL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_raw,
    input  logic [DGL_W-1:0] width,
    output logic             cmp_q
);
    logic [DGL_W-1:0] run_cnt;
    logic             held;
    logic             bypass;

    assign bypass = (width == '0);
    assign cmp_q  = bypass ? cmp_raw : held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            held    <= 1'b0;
        end else if (bypass) begin
            run_cnt <= '0;
            held    <= cmp_raw;
        end else if (cmp_raw == held) begin
            run_cnt <= '0;
        end else if (run_cnt == width - DGL_W'(1)) begin
            run_cnt <= '0;
            held    <= cmp_raw;
        end else begin
            run_cnt <= run_cnt + DGL_W'(1);
        end
    end
endmodule

// File: rtl/vrt_step_ctrl.sv
module vrt_step_ctrl #(
    parameter int REF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             decide,
    input  logic             dir_up,
    input  logic             auto_mode,
    input  logic [REF_W-1:0] fixed_step,
    input  logic [REF_W-1:0] step_max,
    output logic [REF_W-1:0] step_out
);
    localparam logic [REF_W-1:0] ONE = REF_W'(1);

    logic [REF_W-1:0] step_r;
    logic [REF_W-1:0] max_eff;
    logic [REF_W-1:0] halved;
    logic [REF_W-1:0] doubled;
    logic [REF_W:0]   dbl_wide;
    logic             last_up;
    logic             have_last;
    logic             run_r;

    always_comb begin
        max_eff  = (step_max == '0) ? ONE : step_max;
        halved   = ((step_r >> 1) == '0) ? ONE : (step_r >> 1);
        dbl_wide = {step_r, 1'b0};
        doubled  = (dbl_wide > {1'b0, max_eff}) ? max_eff : dbl_wide[REF_W-1:0];
        step_out = auto_mode ? step_r : fixed_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_r    <= ONE;
            last_up   <= 1'b0;
            have_last <= 1'b0;
            run_r     <= 1'b0;
        end else if (start) begin
            step_r    <= ONE;
            have_last <= 1'b0;
            run_r     <= 1'b0;
        end else if (decide && auto_mode) begin
            have_last <= 1'b1;
            last_up   <= dir_up;
            if (have_last && (dir_up != last_up)) begin
                step_r <= halved;
                run_r  <= 1'b0;
            end else if (run_r) begin
                step_r <= doubled;
                run_r  <= 1'b0;
            end else begin
                run_r  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vrt_ref_acc.sv
module vrt_ref_acc #(
    parameter int REF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decide,
    input  logic             dir_up,
    input  logic [REF_W-1:0] step,
    output logic [REF_W-1:0] ref_val
);
    logic [REF_W:0]   sum_wide;
    logic [REF_W-1:0] ref_next;

    always_comb begin
        sum_wide = {1'b0, ref_val} + {1'b0, step};
        if (dir_up)
            ref_next = sum_wide[REF_W] ? {REF_W{1'b1}} : sum_wide[REF_W-1:0];
        else
            ref_next = (step > ref_val) ? '0 : (ref_val - step);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ref_val <= '0;
        else if (decide)
            ref_val <= ref_next;
    end
endmodule

// File: rtl/vrect_tracker.sv
module vrect_tracker
    import vrt_pkg::*;
#(
    parameter int REF_W = 8,
    parameter int DGL_W = 4,
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_en,
    input  logic             cmp_raw,
    input  logic [DGL_W-1:0] cfg_dgl_width,
    input  logic [TMR_W-1:0] cfg_start_thr,
    input  logic             cfg_auto_step,
    input  logic [REF_W-1:0] cfg_fixed_step,
    input  logic [REF_W-1:0] cfg_step_max,
    output logic [REF_W-1:0] ref_out,
    output logic [REF_W-1:0] cap_value,
    output logic             cap_valid
);
    trk_state_e       state, state_nx;
    logic             pwm_d;
    logic             pwm_rise;
    logic             pwm_fall;
    logic [TMR_W-1:0] tmr;
    logic             tmr_done;
    logic             cmp_q;
    logic             trk_act;
    logic             trk_start;
    logic [REF_W-1:0] step_cur;

    assign pwm_rise  = pwm_en & ~pwm_d;
    assign pwm_fall  = ~pwm_en & pwm_d;
    assign tmr_done  = (tmr == cfg_start_thr);
    assign trk_act   = (state == ST_TRACK) && pwm_en;
    assign trk_start = (state == ST_WAIT) && pwm_en && tmr_done;

    vrt_deglitch #(.DGL_W(DGL_W)) i_dgl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_raw (cmp_raw),
        .width   (cfg_dgl_width),
        .cmp_q   (cmp_q)
    );

    vrt_step_ctrl #(.REF_W(REF_W)) i_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (trk_start),
        .decide     (trk_act),
        .dir_up     (cmp_q),
        .auto_mode  (cfg_auto_step),
        .fixed_step (cfg_fixed_step),
        .step_max   (cfg_step_max),
        .step_out   (step_cur)
    );

    vrt_ref_acc #(.REF_W(REF_W)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .decide  (trk_act),
        .dir_up  (cmp_q),
        .step    (step_cur),
        .ref_val (ref_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (pwm_rise) state_nx = ST_WAIT;
            ST_WAIT:  if (!pwm_en) state_nx = ST_IDLE;
                      else if (tmr_done) state_nx = ST_TRACK;
            ST_TRACK: if (!pwm_en) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs: edge history, start timer, capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_d     <= 1'b0;
            tmr       <= '0;
            cap_value <= '0;
            cap_valid <= 1'b0;
        end else begin
            pwm_d     <= pwm_en;
            cap_valid <= pwm_fall;
            if (pwm_fall)
                cap_value <= ref_out;
            if (state != ST_WAIT)
                tmr <= '0;
            else if (!tmr_done)
                tmr <= tmr + TMR_W'(1);
        end
    end
endmodule

// File: rtl/vrt_checker.sv
module vrt_checker #(
    parameter int REF_W = 8,
    parameter int DGL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_raw,
    input logic             cmp_q,
    input logic [DGL_W-1:0] cfg_dgl_width,
    input logic             cfg_auto_step,
    input logic [REF_W-1:0] cfg_step_max,
    input logic [REF_W-1:0] step_cur,
    input logic             trk_act,
    input logic [REF_W-1:0] ref_out,
    input logic [REF_W-1:0] cap_value,
    input logic             cap_valid
);
    logic [REF_W-1:0] max_eff;
    assign max_eff = (cfg_step_max == '0) ? REF_W'(1) : cfg_step_max;

    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dgl_width == '0) |-> (cmp_q == cmp_raw));

    assert_step_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_act && cfg_auto_step) |-> (step_cur >= REF_W'(1) && step_cur <= max_eff));

    assert_sat_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_act && cmp_q && ref_out == {REF_W{1'b1}}) |=> (ref_out == {REF_W{1'b1}}));

    assert_sat_bot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_act && !cmp_q && ref_out == '0) |=> (ref_out == '0));

    assert_cap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);

    assert_cap_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (cap_value == ref_out));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !trk_act |=> $stable(ref_out));
endmodule

bind vrect_tracker vrt_checker #(.REF_W(REF_W), .DGL_W(DGL_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_raw       (cmp_raw),
    .cmp_q         (cmp_q),
    .cfg_dgl_width (cfg_dgl_width),
    .cfg_auto_step (cfg_auto_step),
    .cfg_step_max  (cfg_step_max),
    .step_cur      (step_cur),
    .trk_act       (trk_act),
    .ref_out       (ref_out),
    .cap_value     (cap_value),
    .cap_valid     (cap_valid)
);

// File: tb/test_vrect_tracker.sv
module test_vrect_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_en = 1'b0;
    logic       cmp_raw = 1'b0;
    logic [3:0] cfg_dgl_width = '0;
    logic [7:0] cfg_start_thr = '0;
    logic       cfg_auto_step = 1'b0;
    logic [7:0] cfg_fixed_step = '0;
    logic [7:0] cfg_step_max = '0;
    logic [7:0] ref_out;
    logic [7:0] cap_value;
    logic       cap_valid;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vrect_tracker i_vrect_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwm_en         (pwm_en),
        .cmp_raw        (cmp_raw),
        .cfg_dgl_width  (cfg_dgl_width),
        .cfg_start_thr  (cfg_start_thr),
        .cfg_auto_step  (cfg_auto_step),
        .cfg_fixed_step (cfg_fixed_step),
        .cfg_step_max   (cfg_step_max),
        .ref_out        (ref_out),
        .cap_value      (cap_value),
        .cap_valid      (cap_valid)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic adv(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_run(input logic [3:0] dgl, input logic [7:0] thr,
                             input logic aut, input logic [7:0] fix,
                             input logic [7:0] mx, input logic c0);
        @(negedge clk);
        rst_n          = 1'b0;
        pwm_en         = 1'b0;
        cmp_raw        = c0;
        cfg_dgl_width  = dgl;
        cfg_start_thr  = thr;
        cfg_auto_step  = aut;
        cfg_fixed_step = fix;
        cfg_step_max   = mx;
        adv(2);
        rst_n = 1'b1;
        adv(1);
    endtask

    task automatic t_reset();
        start_run(4'd0, 8'd0, 1'b1, 8'd0, 8'd8, 1'b1);
        check("R1", "ref after reset", ref_out, 0);
        check("R1", "cap_valid after reset", cap_valid, 0);
        check("R1", "cap_value after reset", cap_value, 0);
        adv(3);
        check("R10", "ref with pwm_en low", ref_out, 0);
    endtask

    task automatic t_auto();
        int exp_up[6] = '{1, 2, 4, 6, 10, 14};
        start_run(4'd0, 8'd0, 1'b1, 8'd0, 8'd4, 1'b1);
        pwm_en = 1'b1;
        adv(2);
        check("R4", "ref before first tracking edge", ref_out, 0);
        for (int k = 0; k < 6; k++) begin
            adv(1);
            check("R6", "auto growth", ref_out, exp_up[k]);
        end
        adv(1);
        check("R7", "clamped step E9", ref_out, 18);
        adv(1);
        check("R7", "clamped step E10", ref_out, 22);
        adv(1);
        check("R7", "clamp holds at max E11", ref_out, 26);
        cmp_raw = 1'b0;
        adv(1);
        check("R6", "reversal uses old step", ref_out, 22);
        adv(1);
        check("R6", "halved step", ref_out, 20);
        adv(1);
        check("R5", "down with halved step", ref_out, 18);
        adv(1);
        check("R6", "regrown step", ref_out, 14);
        pwm_en = 1'b0;
        adv(1);
    endtask

    task automatic t_fixed_sat();
        start_run(4'd0, 8'd0, 1'b0, 8'd100, 8'd1, 1'b1);
        pwm_en = 1'b1;
        adv(3);
        check("R8", "fixed step once", ref_out, 100);
        adv(1);
        check("R8", "fixed step twice", ref_out, 200);
        adv(1);
        check("R9", "saturate full scale", ref_out, 255);
        adv(1);
        check("R9", "stay at full scale", ref_out, 255);
        pwm_en = 1'b0;
        adv(1);
    endtask

    task automatic t_timer();
        start_run(4'd0, 8'd4, 1'b0, 8'd5, 8'd1, 1'b1);
        pwm_en = 1'b1;
        adv(6);
        check("R4", "no update before edge T+3", ref_out, 0);
        adv(1);
        check("R4", "update at edge T+3", ref_out, 5);
        pwm_en = 1'b0;
        adv(1);
    endtask

    task automatic t_deglitch();
        start_run(4'd3, 8'd0, 1'b0, 8'd5, 8'd1, 1'b0);
        pwm_en = 1'b1;
        adv(4);
        check("R9", "saturate at zero", ref_out, 0);
        cmp_raw = 1'b1;
        adv(2);
        cmp_raw = 1'b0;
        adv(3);
        check("R3", "short pulse ignored", ref_out, 0);
        cmp_raw = 1'b1;
        adv(3);
        check("R3", "no move before W-cycle delay", ref_out, 0);
        adv(1);
        check("R3", "move after W-cycle delay", ref_out, 5);
        pwm_en = 1'b0;
        adv(1);
    endtask

    task automatic t_bypass();
        start_run(4'd0, 8'd0, 1'b0, 8'd5, 8'd1, 1'b0);
        pwm_en = 1'b1;
        adv(4);
        cmp_raw = 1'b1;
        adv(1);
        check("R2", "bypass no delay", ref_out, 5);
        pwm_en = 1'b0;
        adv(1);
    endtask

    task automatic t_capture();
        start_run(4'd0, 8'd0, 1'b0, 8'd5, 8'd1, 1'b1);
        pwm_en = 1'b1;
        adv(4);
        check("R5", "two up steps", ref_out, 10);
        pwm_en = 1'b0;
        adv(1);
        check("R10", "cap_valid strobe", cap_valid, 1);
        check("R10", "cap_value", cap_value, 10);
        check("R10", "ref frozen at fall", ref_out, 10);
        adv(1);
        check("R10", "strobe one cycle", cap_valid, 0);
        adv(3);
        check("R10", "ref held while low", ref_out, 10);
    endtask

    initial begin
        t_reset();
        t_auto();
        t_fixed_sat();
        t_timer();
        t_deglitch();
        t_bypass();
        t_capture();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule